// File: doc/BRIEF.md
# Serial Gamepad to Parallel Button Bridge

This block is the host end of a 16-bit serial gamepad link. It generates the latch strobe and the data clock the pad expects, samples the serial line the pad returns, and keeps twelve registered button outputs that look like a static parallel joystick port to whatever reads them. Polling frames run back to back, far faster than a console would poll, so the parallel side always shows a fresh view of the pad. An idle gap between frames can be added by parameter to slow the response.

All pulse widths are counted in microsecond ticks. The tick comes from the system clock through a divider set by the clock frequency parameter, so the timing holds at any clock rate. The serial input goes through a two-flop synchronizer before it is sampled. Each output copies the sampled level, so a low output means a pressed button. The four face buttons are moved onto the face-button positions of a different console. The four trailing bits of each frame carry no buttons and are dropped.

Top module: `pad_poller`

## Requirements
- R1: A frame opens with `pad_latch` high for LATCH_US microseconds, where one microsecond is CLK_HZ/1000000 system clock cycles (48 cycles for LATCH_US=12 at 4 MHz), and `pad_clk` is high whenever `pad_latch` is high.
- R2: `pad_clk` idles high and first falls SETUP_US microseconds after `pad_latch` falls; each clock cycle is HALF_US microseconds low, then HALF_US microseconds high.
- R3: Exactly NUM_BITS (16) falling edges of `pad_clk` occur between two rising edges of `pad_latch`.
- R4: At the k-th falling edge of `pad_clk` (k = 0 first), the synchronized level of `pad_data` is stored as serial bit k; serial bit 0 is the first bit after the latch, a low level means pressed and the output copies the level unchanged (active low).
- R5: A bit of `pad_btn_n` changes only on a system clock edge where `pad_clk` falls; between its sample points it holds its value.
- R6: Serial bits 0..11 are B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R. Output positions: [0] face A from Y, [1] face B from B, [2] face C from X, [3] face D from A, [4] Up, [5] Down, [6] Left, [7] Right, [8] Select, [9] Start, [10] L, [11] R.
- R7: Serial bits 12 to 15 have no effect on any output.
- R8: After the sixteenth high phase the next latch rises after GAP_US further microseconds, so the time from the last rising edge of `pad_clk` to the next rising edge of `pad_latch` is HALF_US+GAP_US microseconds; with GAP_US=0 it follows at once.
- R9: While `rst_n` is low, and at any time it is driven low, `pad_latch` is 0, `pad_clk` is 1 and all of `pad_btn_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_data | input | 1 | Serial button data returned by the pad |
| pad_latch | output | 1 | Latch strobe to the pad, active high |
| pad_clk | output | 1 | Data clock to the pad, idles high |
| pad_btn_n | output | 12 | Parallel active-low button outputs, positions as in R6 |

## Verification
The bound checker watches the link waveform on every cycle: latch width, the low width of each clock cycle, the clock staying high under the latch, the count of sixteen falling edges per frame and the rule that outputs move only where the clock falls. Whether the right serial bit lands on the right output, the face-button remap, the dropping of the trailing bits, the setup delay, the idle gap and the reset values are shown only by the bench, which drives a model pad with distinct button words and compares each frame's outputs against values derived from the pin map.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;

  // sequencer phases
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LATCH = 3'd1,
    PH_SETUP = 3'd2,
    PH_LOW   = 3'd3,
    PH_HIGH  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // number of parallel button outputs
  localparam int unsigned NUM_BTN = 12;

  // serial bit index that feeds a given output position
  function automatic int unsigned src_bit(input int unsigned out_pos);
    case (out_pos)
      0:       return 1;   // face A <- Y
      1:       return 0;   // face B <- B
      2:       return 9;   // face C <- X
      3:       return 8;   // face D <- A
      8:       return 2;   // Select
      9:       return 3;   // Start
      default: return out_pos;
    endcase
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pad_poll_sync.sv
module pad_poll_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {2{RST_VAL}};
    end else begin
      stage_q <= {stage_q[0], d_i};
    end
  end

  assign q_o = stage_q[1];

endmodule

// File: rtl/pad_poll_tick.sv
module pad_poll_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pad_poll_seq.sv
module pad_poll_seq
  import pad_poll_pkg::*;
#(
  parameter int unsigned LATCH_US = 12,
  parameter int unsigned SETUP_US = 6,
  parameter int unsigned HALF_US  = 6,
  parameter int unsigned GAP_US   = 0,
  parameter int unsigned NUM_BITS = 16,
  parameter int unsigned BIT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             latch_o,
  output logic             sclk_o,
  output logic             smp_en_o,
  output logic [BIT_W-1:0] smp_idx_o
);

  localparam int unsigned MAXLEN  = max_of(max_of(LATCH_US, SETUP_US), max_of(HALF_US, GAP_US));
  localparam int unsigned CNT_W   = $clog2(MAXLEN + 1);
  localparam int unsigned GAP_LEN = (GAP_US == 0) ? 1 : GAP_US;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_BITS - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             latch_q, sclk_q;
  logic [CNT_W-1:0] len;
  logic             ph_end;
  logic             smp_en;

  // phase length in ticks
  always_comb begin
    case (state_q)
      PH_LATCH: len = CNT_W'(LATCH_US);
      PH_SETUP: len = CNT_W'(SETUP_US);
      PH_LOW:   len = CNT_W'(HALF_US);
      PH_HIGH:  len = CNT_W'(HALF_US);
      PH_GAP:   len = CNT_W'(GAP_LEN);
      default:  len = CNT_W'(1);
    endcase
  end

  // next state
  always_comb begin
    ph_end  = tick_i && (cnt_q == len - CNT_W'(1));
    state_d = state_q;
    cnt_d   = tick_i ? cnt_q + CNT_W'(1) : cnt_q;
    bit_d   = bit_q;
    smp_en  = 1'b0;
    if (ph_end) begin
      cnt_d = '0;
      case (state_q)
        PH_IDLE:  state_d = PH_LATCH;
        PH_LATCH: state_d = PH_SETUP;
        PH_SETUP: begin
          state_d = PH_LOW;
          bit_d   = '0;
          smp_en  = 1'b1;
        end
        PH_LOW:   state_d = PH_HIGH;
        PH_HIGH: begin
          if (bit_q == LAST_BIT) begin
            state_d = (GAP_US > 0) ? PH_GAP : PH_LATCH;
          end else begin
            state_d = PH_LOW;
            bit_d   = bit_q + BIT_W'(1);
            smp_en  = 1'b1;
          end
        end
        PH_GAP:   state_d = PH_LATCH;
        default:  state_d = PH_IDLE;
      endcase
    end
  end

  // registers, pad pins decoded from the next state so they leave a flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      latch_q <= 1'b0;
      sclk_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      latch_q <= (state_d == PH_LATCH);
      sclk_q  <= (state_d != PH_LOW);
    end
  end

  assign latch_o   = latch_q;
  assign sclk_o    = sclk_q;
  assign smp_en_o  = smp_en;
  assign smp_idx_o = bit_d;

endmodule

// File: rtl/pad_poll_map.sv
module pad_poll_map
  import pad_poll_pkg::*;
#(
  parameter int unsigned BIT_W   = 4,
  parameter int unsigned NUM_OUT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en_i,
  input  logic [BIT_W-1:0]   smp_idx_i,
  input  logic               din_i,
  output logic [NUM_OUT-1:0] btn_n_o
);

  logic [NUM_OUT-1:0] btn_q;
  logic [NUM_OUT-1:0] btn_d;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_pos
    localparam int unsigned SRC = src_bit(j);
    logic hit;
    always_comb begin
      hit      = smp_en_i && (smp_idx_i == BIT_W'(SRC));
      btn_d[j] = hit ? din_i : btn_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q <= '1;
    end else begin
      btn_q <= btn_d;
    end
  end

  assign btn_n_o = btn_q;

endmodule

// File: rtl/pad_poller.sv
module pad_poller
  import pad_poll_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned LATCH_US = 12,
  parameter int unsigned SETUP_US = 6,
  parameter int unsigned HALF_US  = 6,
  parameter int unsigned GAP_US   = 0,
  parameter int unsigned NUM_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pad_data,
  output logic               pad_latch,
  output logic               pad_clk,
  output logic [NUM_BTN-1:0] pad_btn_n
);

  localparam int unsigned TICK_DIV  = CLK_HZ / 1_000_000;
  localparam int unsigned BIT_W     = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
  localparam int unsigned LATCH_CYC = LATCH_US * TICK_DIV;
  localparam int unsigned HALF_CYC  = HALF_US * TICK_DIV;

  logic             rst_int_n;
  logic             tick;
  logic             data_s;
  logic             smp_en;
  logic [BIT_W-1:0] smp_idx;

  pad_poll_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  pad_poll_sync #(.RST_VAL(1'b1)) u_data_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pad_data),
    .q_o   (data_s)
  );

  pad_poll_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  pad_poll_seq #(
    .LATCH_US (LATCH_US),
    .SETUP_US (SETUP_US),
    .HALF_US  (HALF_US),
    .GAP_US   (GAP_US),
    .NUM_BITS (NUM_BITS),
    .BIT_W    (BIT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .latch_o   (pad_latch),
    .sclk_o    (pad_clk),
    .smp_en_o  (smp_en),
    .smp_idx_o (smp_idx)
  );

  pad_poll_map #(
    .BIT_W   (BIT_W),
    .NUM_OUT (NUM_BTN)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .smp_en_i  (smp_en),
    .smp_idx_i (smp_idx),
    .din_i     (data_s),
    .btn_n_o   (pad_btn_n)
  );

endmodule

// File: rtl/pad_poller_chk.sv
module pad_poller_chk #(
  parameter int unsigned LATCH_CYC = 48,
  parameter int unsigned HALF_CYC  = 24,
  parameter int unsigned NUM_BITS  = 16,
  parameter int unsigned NUM_OUT   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pad_latch,
  input logic               pad_clk,
  input logic [NUM_OUT-1:0] pad_btn_n
);

  logic [31:0] lat_run, low_run, fall_cnt;
  logic        lat_prev, clk_prev, seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_run    <= '0;
      low_run    <= '0;
      fall_cnt   <= '0;
      lat_prev   <= 1'b0;
      clk_prev   <= 1'b1;
      seen_frame <= 1'b0;
    end else begin
      lat_prev <= pad_latch;
      clk_prev <= pad_clk;
      lat_run  <= pad_latch ? lat_run + 32'd1 : 32'd0;
      low_run  <= pad_clk ? 32'd0 : low_run + 32'd1;
      if (pad_latch && !lat_prev) begin
        fall_cnt   <= '0;
        seen_frame <= 1'b1;
      end else if (!pad_clk && clk_prev) begin
        fall_cnt <= fall_cnt + 32'd1;
      end
    end
  end

  // R1: latch width
  p_latch_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_latch) |-> (lat_run == LATCH_CYC));

  // R1: clock held high under the latch
  p_clk_high_in_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch |-> pad_clk);

  // R2: low half of each clock cycle
  p_low_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_clk) |-> (low_run == HALF_CYC));

  // R3: sixteen falling edges per frame
  p_falls_per_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pad_latch) && seen_frame) |-> (fall_cnt == NUM_BITS));

  // R5: outputs move only where the data clock falls
  p_btn_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_btn_n != $past(pad_btn_n)) |-> $fell(pad_clk));

endmodule

bind pad_poller pad_poller_chk #(
  .LATCH_CYC (LATCH_CYC),
  .HALF_CYC  (HALF_CYC),
  .NUM_BITS  (NUM_BITS),
  .NUM_OUT   (NUM_BTN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_latch (pad_latch),
  .pad_clk   (pad_clk),
  .pad_btn_n (pad_btn_n)
);

// File: tb/tb_pad_poller.sv
`timescale 1ns/1ps
module tb_pad_poller;

  localparam int unsigned CLK_HZ  = 4_000_000;
  localparam int unsigned DIV     = CLK_HZ / 1_000_000;
  localparam int unsigned GAP_US  = 5;
  localparam int unsigned LAT_CYC = 12 * DIV;
  localparam int unsigned HLF_CYC = 6 * DIV;
  localparam int unsigned SU_CYC  = 6 * DIV;
  localparam int unsigned TAIL    = (6 + GAP_US) * DIV;
  localparam int NW = 10;

  logic        clk;
  logic        rst_n;
  logic        pad_data;
  logic        pad_latch;
  logic        pad_clk;
  logic [11:0] pad_btn_n;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit mon_on = 0;
  int compared = 0;
  int r5_bad = 0;

  logic [11:0] sb_q[$];

  pad_poller #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_data  (pad_data),
    .pad_latch (pad_latch),
    .pad_clk   (pad_clk),
    .pad_btn_n (pad_btn_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] word_of(input int i);
    case (i)
      0: return 16'hFFFF;
      1: return 16'hFFFE;   // B pressed
      2: return 16'hFFFD;   // Y pressed
      3: return 16'hFEFF;   // A pressed
      4: return 16'hFDFF;   // X pressed
      5: return 16'h0FFF;   // only trailing bits low
      6: return 16'h0000;
      7: return 16'hAAAA;
      8: return 16'h5555;
      9: return 16'hFFF3;   // Select, Start pressed
      default: return 16'hFFFF;
    endcase
  endfunction

  // pin map of R6
  function automatic logic [11:0] expect_of(input logic [15:0] w);
    logic [11:0] e;
    e[0] = w[1];  e[1] = w[0];  e[2] = w[9];  e[3] = w[8];
    e[4] = w[4];  e[5] = w[5];  e[6] = w[6];  e[7] = w[7];
    e[8] = w[2];  e[9] = w[3];  e[10] = w[10]; e[11] = w[11];
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pad model and scoreboard driver
  initial begin : pad_model
    int fi = 0;
    pad_data = 1'b1;
    forever begin
      logic [15:0] sh;
      @(posedge pad_latch);
      sh = word_of(fi);
      if (mon_on) sb_q.push_back(expect_of(sh));
      fi++;
      pad_data = sh[0];
      for (int k = 1; k <= 16; k++) begin
        @(posedge pad_clk);
        pad_data = (k < 16) ? sh[k] : 1'b0;
      end
    end
  end

  // monitors
  int lat_run = 0, low_run = 0, su_cnt = 0, falls = 0, tail = 0, frames = 0;
  bit in_su = 0;
  logic prev_lat = 1'b0, prev_clk = 1'b1;
  logic [11:0] prev_btn = '1;

  always @(negedge clk) begin
    if (mon_on) begin
      // R1 latch width
      if (pad_latch) lat_run++;
      else begin
        if (prev_lat) check(lat_run == LAT_CYC, "R1 latch width", lat_run, LAT_CYC);
        lat_run = 0;
      end
      // R2 low half width
      if (!pad_clk) low_run++;
      else begin
        if (!prev_clk) check(low_run == HLF_CYC, "R2 clock low width", low_run, HLF_CYC);
        low_run = 0;
      end
      // R2 setup from latch fall to first clock fall
      if (prev_lat && !pad_latch) begin in_su = 1; su_cnt = 0; end
      if (in_su) begin
        if (pad_clk) su_cnt++;
        else begin
          check(su_cnt == SU_CYC, "R2 setup delay", su_cnt, SU_CYC);
          in_su = 0;
        end
      end
      // R3, R8 and scoreboard at each latch rise
      if (pad_latch && !prev_lat) begin
        if (frames > 0) begin
          check(falls == 16, "R3 falls per frame", falls, 16);
          check(tail == TAIL, "R8 idle gap", tail, TAIL);
        end
        if (sb_q.size() >= 2) begin
          logic [11:0] e;
          e = sb_q.pop_front();
          check(pad_btn_n == e, "R4 R6 R7 frame outputs", pad_btn_n, e);
          compared++;
        end
        frames++;
        falls = 0;
      end
      if (!pad_clk && prev_clk) falls++;
      if (pad_clk) tail = prev_clk ? tail + 1 : 1;
      // R5 outputs move only at clock falls
      if (pad_btn_n != prev_btn && !(prev_clk && !pad_clk)) r5_bad++;
    end
    prev_lat = pad_latch;
    prev_clk = pad_clk;
    prev_btn = pad_btn_n;
  end

  initial begin : main
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(pad_latch == 1'b0, "R9 reset latch", pad_latch, 0);
    check(pad_clk == 1'b1, "R9 reset clock", pad_clk, 1);
    check(pad_btn_n == 12'hFFF, "R9 reset outputs", pad_btn_n, 12'hFFF);
    rst_n = 1'b1;
    mon_on = 1;
    while (compared < NW - 1) @(negedge clk);
    // mid-frame reset while buttons show a pressed pattern
    @(negedge pad_clk);
    repeat (3) @(negedge clk);
    mon_on = 0;
    check(r5_bad == 0, "R5 changes outside clock falls", r5_bad, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(pad_latch == 1'b0, "R9 async reset latch", pad_latch, 0);
    check(pad_clk == 1'b1, "R9 async reset clock", pad_clk, 1);
    check(pad_btn_n == 12'hFFF, "R9 async reset outputs", pad_btn_n, 12'hFFF);
    check(compared == NW - 1, "R4 frames compared", compared, NW - 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", compared, NW - 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule